// File: doc/BRIEF.md
# Buck Regulator Start-up and Fault Sequencer

This block is the supervisory state machine of a synchronous buck regulator. It decides when the power stage may switch, when the low-side switch must be held on to drain the output, when the analog soft-start ramp must restart, and when the open-drain power-good output must be pulled low. Its inputs are comparator levels that have already been digitised: enable, deep disable, two supply lockouts, over-voltage, under-voltage and over-temperature flags. It also takes a soft-start-complete flag, a per-switching-cycle overcurrent report and a configuration bit that chooses latch-off or hiccup recovery.

All timing is counted on the system clock. Each fault has its own blanking window. The overcurrent path counts consecutive switching cycles that report an event. Hiccup recovery waits four soft-start periods and then ramps up again. During that recovery ramp only overcurrent is watched. During an ordinary ramp, overcurrent and over-temperature are both watched.

Top module: `pwr_fault_seq`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it, `swEnable`=0, `lowSideForce`=0, `ssRestart`=0 and `pgPullLow`=1.
- R2: From off, a ramp begins on the first clock edge at which `enAbove`=1 and `deepOff`, `vinLockout` and `biasLockout` are all 0. At that edge `swEnable` becomes 1, and `ssRestart` is 1 for exactly one cycle. No ramp begins while any of those conditions is missing.
- R3: In every state other than latch-off, `deepOff`=1, `enAbove`=0 or either lockout flag returns the block to off on the next edge, with both switch commands 0 and `pgPullLow`=1.
- R4: `ssDone`=1 during a ramp moves the block into regulation. `pgPullLow` is 0 only in regulation, and only while `ovFlag`, `uvFlag` and `otFlag` are all 0.
- R5: Each clock with `cycleEnd`=1 closes one switching cycle. That cycle counts as an event if `cycleOcp`=1 in the same clock, and a cycle without one clears the count. The edge that closes the third consecutive event cycle is a fault. That fault leads to hiccup when `latchSel`=0 (both switch commands 0) and to latch-off when `latchSel`=1.
- R6: Hiccup holds both switch commands at 0 for exactly 4*`SS_PERIOD` clocks. It then starts a recovery ramp with a one-cycle `ssRestart` pulse.
- R7: During a recovery ramp only overcurrent is acted on. `otFlag`, `ovFlag` and `uvFlag` leave the switch commands unchanged.
- R8: During an ordinary ramp overcurrent and over-temperature are acted on. `ovFlag` and `uvFlag` leave the switch commands unchanged.
- R9: In regulation, `ovFlag` high on `OV_BLANK` consecutive edges sets an over-voltage hold: `swEnable`=0, `lowSideForce`=1, `pgPullLow`=1. If the flag drops for one clock, the window restarts.
- R10: In over-voltage hold, the first edge with `uvFlag`=1 enters latch-off when `latchSel`=1 and hiccup when `latchSel`=0.
- R11: In regulation, `uvFlag` high on `UV_BLANK` consecutive edges enters hiccup whatever the value of `latchSel`. If the flag drops for one clock, the window restarts.
- R12: `otFlag`=1 during a ordinary ramp or in regulation turns both switches off on the next edge. When the flag clears, a new ramp starts with a `ssRestart` pulse. In regulation the priority is over-temperature, then overcurrent, then over-voltage, then under-voltage.
- R13: Latch-off holds `swEnable`=0 and `lowSideForce`=1 and ignores enable and lockout inputs. Only `rstN` releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-cycle reset |
| enAbove | input | 1 | Enable comparator is above its threshold |
| deepOff | input | 1 | Enable level is below the deep-disable threshold |
| vinLockout | input | 1 | Input supply lockout active |
| biasLockout | input | 1 | Internal bias supply lockout active |
| ssDone | input | 1 | Soft-start ramp has finished |
| cycleEnd | input | 1 | One-clock marker closing a switching cycle |
| cycleOcp | input | 1 | Overcurrent seen in the cycle being closed |
| ovFlag | input | 1 | Output over-voltage comparator |
| uvFlag | input | 1 | Output under-voltage comparator |
| otFlag | input | 1 | Over-temperature comparator |
| latchSel | input | 1 | 1 selects latch-off recovery, 0 selects hiccup |
| swEnable | output | 1 | Power stage may switch |
| lowSideForce | output | 1 | Hold the low-side switch on, high side off |
| ssRestart | output | 1 | One-cycle pulse restarting the soft-start ramp |
| pgPullLow | output | 1 | Drive the open-drain power-good pin low |

## Verification
Every switch command is decoded from the state register, so a state change shows on `swEnable` and `lowSideForce` in the cycle after the edge that causes it. `ssRestart` is registered on that same edge. A blanking window of N clocks therefore trips on the Nth consecutive edge with the flag high. Hiccup ends on edge 4*`SS_PERIOD` after the entry edge. The overcurrent fault lands on the edge that closes the third event cycle. The bench drives inputs on falling edges and samples on falling edges. It checks one clock before each due edge that nothing has moved yet, and checks right after the due edge that the change has happened. A one-cycle slip in any direction is therefore reported. `pgPullLow` also follows the fault flags combinationally in regulation, and the bench checks it while a flag is held.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RUN     = 3'd2,
    ST_OVHOLD  = 3'd3,
    ST_HICWAIT = 3'd4,
    ST_HICSOFT = 3'd5,
    ST_HOT     = 3'd6,
    ST_LATCH   = 3'd7
  } seqState_t;

  // strobes from control to the timing datapath
  typedef struct packed {
    logic ocpArm;
    logic ovArm;
    logic uvArm;
    logic hicRun;
  } seqStrobe_t;

endpackage

// File: rtl/pfs_blank_timer.sv
module pfs_blank_timer #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic arm,
  input  logic flag,
  output logic trip
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                runCnt <= '0;
    else if (!(arm && flag))  runCnt <= '0;
    else if (runCnt != LAST)  runCnt <= runCnt + 1'b1;
  end

  // trips on the LEN-th consecutive armed edge with the flag high
  assign trip = arm && flag && (runCnt == LAST);

  generate
    if (LEN > 1) begin : g_chk
      // R9 / R11 / R6: a window longer than one clock needs the flag in the previous cycle too
      assert_window_held_R9: assert property (@(posedge clk) disable iff (!rstN)
        trip |-> $past(flag) && $past(arm));
    end
  endgenerate

endmodule

// File: rtl/pfs_datapath.sv
module pfs_datapath
  import pfs_pkg::*;
#(
  parameter int OCP_LIMIT   = 3,
  parameter int OV_BLANK    = 625_000,
  parameter int UV_BLANK    = 2_500_000,
  parameter int SS_PERIOD   = 125_000,
  parameter int HIC_PERIODS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       cycleEnd,
  input  logic       cycleOcp,
  input  logic       ovFlag,
  input  logic       uvFlag,
  output logic       ocpTrip,
  output logic       ovTrip,
  output logic       uvTrip,
  output logic       hicDone
);
  localparam int HIC_LEN = HIC_PERIODS * SS_PERIOD;
  localparam int OCW     = $clog2(OCP_LIMIT + 1);
  localparam logic [OCW-1:0] OCP_LAST = OCW'(OCP_LIMIT - 1);

  logic [OCW-1:0] ocpRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ocpRun <= '0;
    else if (!strobe.ocpArm) ocpRun <= '0;
    else if (cycleEnd) begin
      if (!cycleOcp)             ocpRun <= '0;
      else if (ocpRun != OCP_LAST) ocpRun <= ocpRun + 1'b1;
    end
  end

  assign ocpTrip = strobe.ocpArm && cycleEnd && cycleOcp && (ocpRun == OCP_LAST);

  generate
    if (OCP_LIMIT > 1) begin : g_ocpChk
      // R5: a clean cycle clears the run, so the very next clock cannot trip
      assert_clean_cycle_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.ocpArm && cycleEnd && !cycleOcp) |=> !ocpTrip);
    end
  endgenerate

  pfs_blank_timer #(.LEN(OV_BLANK)) u_ovWin (
    .clk(clk), .rstN(rstN), .arm(strobe.ovArm), .flag(ovFlag), .trip(ovTrip));

  pfs_blank_timer #(.LEN(UV_BLANK)) u_uvWin (
    .clk(clk), .rstN(rstN), .arm(strobe.uvArm), .flag(uvFlag), .trip(uvTrip));

  pfs_blank_timer #(.LEN(HIC_LEN)) u_hicWin (
    .clk(clk), .rstN(rstN), .arm(1'b1), .flag(strobe.hicRun), .trip(hicDone));

endmodule

// File: rtl/pfs_control.sv
module pfs_control
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enAbove,
  input  logic       deepOff,
  input  logic       vinLockout,
  input  logic       biasLockout,
  input  logic       ssDone,
  input  logic       ovFlag,
  input  logic       uvFlag,
  input  logic       otFlag,
  input  logic       latchSel,
  input  logic       ocpTrip,
  input  logic       ovTrip,
  input  logic       uvTrip,
  input  logic       hicDone,
  output seqStrobe_t strobe,
  output logic       swEnable,
  output logic       lowSideForce,
  output logic       ssRestart,
  output logic       pgPullLow
);
  seqState_t state, nextState, faultDest;
  logic stopReq;

  assign stopReq   = deepOff || !enAbove || vinLockout || biasLockout;
  assign faultDest = latchSel ? ST_LATCH : ST_HICWAIT;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:     if (!stopReq) nextState = ST_SOFT;
      ST_SOFT: begin
        if (otFlag)       nextState = ST_HOT;
        else if (ocpTrip) nextState = faultDest;
        else if (ssDone)  nextState = ST_RUN;
      end
      ST_RUN: begin
        if (otFlag)       nextState = ST_HOT;
        else if (ocpTrip) nextState = faultDest;
        else if (ovTrip)  nextState = ST_OVHOLD;
        else if (uvTrip)  nextState = ST_HICWAIT;
      end
      ST_OVHOLD:  if (uvFlag)  nextState = faultDest;
      ST_HICWAIT: if (hicDone) nextState = ST_HICSOFT;
      ST_HICSOFT: begin
        if (ocpTrip)      nextState = faultDest;
        else if (ssDone)  nextState = ST_RUN;
      end
      ST_HOT:     if (!otFlag) nextState = ST_SOFT;
      ST_LATCH:   nextState = ST_LATCH;
      default:    nextState = ST_OFF;
    endcase
    if (stopReq && state != ST_LATCH) nextState = ST_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      ssRestart <= 1'b0;
    end else begin
      state     <= nextState;
      ssRestart <= (nextState != state) &&
                   (nextState == ST_SOFT || nextState == ST_HICSOFT);
    end
  end

  always_comb begin
    strobe.ocpArm = (state == ST_SOFT) || (state == ST_RUN) || (state == ST_HICSOFT);
    strobe.ovArm  = (state == ST_RUN);
    strobe.uvArm  = (state == ST_RUN);
    strobe.hicRun = (state == ST_HICWAIT);
  end

  assign swEnable     = (state == ST_SOFT) || (state == ST_RUN) || (state == ST_HICSOFT);
  assign lowSideForce = (state == ST_OVHOLD) || (state == ST_LATCH);
  assign pgPullLow    = (state != ST_RUN) || ovFlag || uvFlag || otFlag;

  // R13: latch-off never exits without reset
  assert_latch_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH) |=> (state == ST_LATCH));

  // R2: restart request is a single-cycle pulse
  assert_restart_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    ssRestart |=> !ssRestart);

  // R4: power-good can only be released after switching was already running
  assert_pg_after_switch_R4: assert property (@(posedge clk) disable iff (!rstN)
    !pgPullLow |-> $past(swEnable));

endmodule

// File: rtl/pwr_fault_seq.sv
module pwr_fault_seq
  import pfs_pkg::*;
#(
  parameter int OCP_LIMIT   = 3,
  parameter int OV_BLANK    = 625_000,
  parameter int UV_BLANK    = 2_500_000,
  parameter int SS_PERIOD   = 125_000,
  parameter int HIC_PERIODS = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic enAbove,
  input  logic deepOff,
  input  logic vinLockout,
  input  logic biasLockout,
  input  logic ssDone,
  input  logic cycleEnd,
  input  logic cycleOcp,
  input  logic ovFlag,
  input  logic uvFlag,
  input  logic otFlag,
  input  logic latchSel,
  output logic swEnable,
  output logic lowSideForce,
  output logic ssRestart,
  output logic pgPullLow
);
  seqStrobe_t strobe;
  logic ocpTrip, ovTrip, uvTrip, hicDone;

  pfs_datapath #(
    .OCP_LIMIT(OCP_LIMIT), .OV_BLANK(OV_BLANK), .UV_BLANK(UV_BLANK),
    .SS_PERIOD(SS_PERIOD), .HIC_PERIODS(HIC_PERIODS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cycleEnd(cycleEnd), .cycleOcp(cycleOcp),
    .ovFlag(ovFlag), .uvFlag(uvFlag),
    .ocpTrip(ocpTrip), .ovTrip(ovTrip), .uvTrip(uvTrip), .hicDone(hicDone)
  );

  pfs_control u_ctl (
    .clk(clk), .rstN(rstN),
    .enAbove(enAbove), .deepOff(deepOff),
    .vinLockout(vinLockout), .biasLockout(biasLockout),
    .ssDone(ssDone), .ovFlag(ovFlag), .uvFlag(uvFlag), .otFlag(otFlag),
    .latchSel(latchSel),
    .ocpTrip(ocpTrip), .ovTrip(ovTrip), .uvTrip(uvTrip), .hicDone(hicDone),
    .strobe(strobe),
    .swEnable(swEnable), .lowSideForce(lowSideForce),
    .ssRestart(ssRestart), .pgPullLow(pgPullLow)
  );

endmodule

// File: tb/sim_pwr_fault_seq.sv
`timescale 1ns/1ps
module sim_pwr_fault_seq;
  localparam int OVB = 8;
  localparam int UVB = 12;
  localparam int SSP = 5;
  localparam int HIC = 4 * SSP;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enAbove = 0, deepOff = 0, vinLockout = 0, biasLockout = 0, ssDone = 0;
  logic cycleEnd = 0, cycleOcp = 0, ovFlag = 0, uvFlag = 0, otFlag = 0, latchSel = 0;
  logic swEnable, lowSideForce, ssRestart, pgPullLow;

  int tests = 0;
  int failed = 0;
  bit allDone = 0;

  always #4 clk = ~clk;

  pwr_fault_seq #(.OV_BLANK(OVB), .UV_BLANK(UVB), .SS_PERIOD(SSP)) u0 (
    .clk(clk), .rstN(rstN), .enAbove(enAbove), .deepOff(deepOff),
    .vinLockout(vinLockout), .biasLockout(biasLockout), .ssDone(ssDone),
    .cycleEnd(cycleEnd), .cycleOcp(cycleOcp), .ovFlag(ovFlag), .uvFlag(uvFlag),
    .otFlag(otFlag), .latchSel(latchSel),
    .swEnable(swEnable), .lowSideForce(lowSideForce),
    .ssRestart(ssRestart), .pgPullLow(pgPullLow));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0;
    enAbove = 0; deepOff = 0; vinLockout = 0; biasLockout = 0; ssDone = 0;
    cycleEnd = 0; cycleOcp = 0; ovFlag = 0; uvFlag = 0; otFlag = 0; latchSel = 0;
    tick(2);
    rstN = 1;
    tick(1);
  endtask

  task automatic toSoft();
    doReset();
    enAbove = 1;
    tick(1);
  endtask

  task automatic toRun();
    toSoft();
    tick(1);
    ssDone = 1;
    tick(1);
    ssDone = 0;
  endtask

  task automatic ocpCycle(input logic hit);
    cycleEnd = 1; cycleOcp = hit;
    tick(1);
    cycleEnd = 0; cycleOcp = 0;
  endtask

  task automatic testReset();
    rstN = 0;
    tick(1);
    chk("R1", "sw in reset", swEnable, 0);
    chk("R1", "pg in reset", pgPullLow, 1);
    doReset();
    chk("R1", "sw after reset", swEnable, 0);
    chk("R1", "ls after reset", lowSideForce, 0);
    chk("R1", "restart after reset", ssRestart, 0);
    chk("R1", "pg after reset", pgPullLow, 1);
  endtask

  task automatic testStart();
    doReset();
    enAbove = 1; vinLockout = 1;
    tick(3);
    chk("R2", "no start under lockout sw", swEnable, 0);
    chk("R2", "no start under lockout pulse", ssRestart, 0);
    vinLockout = 0;
    tick(1);
    chk("R2", "ramp begins sw", swEnable, 1);
    chk("R2", "ramp begins pulse", ssRestart, 1);
    chk("R4", "pg low in ramp", pgPullLow, 1);
    tick(1);
    chk("R2", "pulse one cycle", ssRestart, 0);
    ssDone = 1;
    tick(1);
    ssDone = 0;
    chk("R4", "pg released in regulation", pgPullLow, 0);
    ovFlag = 1;
    tick(1);
    chk("R4", "pg low while ov flag", pgPullLow, 1);
    ovFlag = 0;
    tick(1);
    chk("R4", "pg released again", pgPullLow, 0);
  endtask

  task automatic testStop();
    toRun();
    biasLockout = 1;
    tick(1);
    chk("R3", "bias lockout stops sw", swEnable, 0);
    chk("R3", "bias lockout pg", pgPullLow, 1);
    biasLockout = 0;
    tick(1);
    chk("R2", "restart after lockout pulse", ssRestart, 1);
    deepOff = 1;
    tick(1);
    chk("R3", "deep disable stops sw", swEnable, 0);
    chk("R3", "deep disable ls", lowSideForce, 0);
    deepOff = 0; enAbove = 0;
    tick(2);
    chk("R3", "enable low stays off", swEnable, 0);
  endtask

  task automatic testOcpHiccup();
    toRun();
    ocpCycle(1); ocpCycle(1); ocpCycle(0); ocpCycle(1); ocpCycle(1);
    chk("R5", "broken run no fault", swEnable, 1);
    ocpCycle(1);
    chk("R5", "third event hiccup sw", swEnable, 0);
    chk("R5", "third event hiccup ls", lowSideForce, 0);
    tick(HIC - 1);
    chk("R6", "still waiting", swEnable, 0);
    tick(1);
    chk("R6", "recovery ramp sw", swEnable, 1);
    chk("R6", "recovery ramp pulse", ssRestart, 1);
    otFlag = 1; ovFlag = 1; uvFlag = 1;
    tick(UVB + 2);
    chk("R7", "recovery ignores ot/ov/uv sw", swEnable, 1);
    chk("R7", "recovery ignores ot/ov/uv ls", lowSideForce, 0);
    otFlag = 0; ovFlag = 0; uvFlag = 0;
    ocpCycle(1); ocpCycle(1); ocpCycle(1);
    chk("R7", "recovery acts on ocp", swEnable, 0);
  endtask

  task automatic testOcpLatch();
    doReset();
    latchSel = 1; enAbove = 1;
    tick(2);
    ssDone = 1; tick(1); ssDone = 0;
    ocpCycle(1); ocpCycle(1); ocpCycle(1);
    chk("R5", "latch select sw", swEnable, 0);
    chk("R5", "latch select ls", lowSideForce, 1);
    enAbove = 0; vinLockout = 1;
    tick(3);
    chk("R13", "latch ignores enable ls", lowSideForce, 1);
    chk("R13", "latch ignores enable sw", swEnable, 0);
    doReset();
    chk("R13", "reset releases latch", lowSideForce, 0);
  endtask

  task automatic testOv();
    toRun();
    ovFlag = 1; tick(OVB - 1);
    ovFlag = 0; tick(1);
    ovFlag = 1; tick(OVB - 1);
    chk("R9", "window restarted sw", swEnable, 1);
    chk("R9", "window restarted ls", lowSideForce, 0);
    tick(1);
    chk("R9", "ov hold sw", swEnable, 0);
    chk("R9", "ov hold ls", lowSideForce, 1);
    chk("R9", "ov hold pg", pgPullLow, 1);
    ovFlag = 0;
    tick(5);
    chk("R10", "hold waits for uv", lowSideForce, 1);
    uvFlag = 1;
    tick(1);
    uvFlag = 0;
    chk("R10", "uv ends hold into hiccup ls", lowSideForce, 0);
    chk("R10", "hiccup sw", swEnable, 0);
    // latch variant
    doReset();
    latchSel = 1; enAbove = 1;
    tick(2);
    ssDone = 1; tick(1); ssDone = 0;
    ovFlag = 1; tick(OVB); ovFlag = 0;
    uvFlag = 1; tick(1); uvFlag = 0;
    enAbove = 0;
    tick(2);
    chk("R10", "uv ends hold into latch", lowSideForce, 1);
  endtask

  task automatic testUv();
    doReset();
    latchSel = 1; enAbove = 1;
    tick(2);
    ssDone = 1; tick(1); ssDone = 0;
    uvFlag = 1; tick(UVB - 1);
    uvFlag = 0; tick(1);
    uvFlag = 1; tick(UVB - 1);
    chk("R11", "uv window restarted", swEnable, 1);
    tick(1);
    uvFlag = 0;
    chk("R11", "uv fault sw", swEnable, 0);
    chk("R11", "uv hiccup not latch", lowSideForce, 0);
  endtask

  task automatic testOtAndRamp();
    toSoft();
    tick(1);
    ovFlag = 1; uvFlag = 1;
    tick(UVB + 2);
    chk("R8", "ramp ignores ov/uv sw", swEnable, 1);
    chk("R8", "ramp ignores ov/uv ls", lowSideForce, 0);
    ovFlag = 0; uvFlag = 0;
    otFlag = 1;
    tick(1);
    chk("R8", "ramp acts on ot", swEnable, 0);
    tick(2);
    otFlag = 0;
    tick(1);
    chk("R12", "ot clear restarts sw", swEnable, 1);
    chk("R12", "ot clear restarts pulse", ssRestart, 1);
    toRun();
    otFlag = 1; ovFlag = 1;
    tick(1);
    chk("R12", "ot in regulation sw", swEnable, 0);
    chk("R12", "ot in regulation ls", lowSideForce, 0);
    otFlag = 0; ovFlag = 0;
  endtask

  initial begin
    testReset();
    testStart();
    testStop();
    testOcpHiccup();
    testOcpLatch();
    testOv();
    testUv();
    testOtAndRamp();
    allDone = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!allDone) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

endmodule